// File: doc/BRIEF.md
# Serial Flash Page-Verify Sequencer

This block sits on the host side of an SPI link to a serial flash that holds an SRAM page buffer. It confirms that a page was programmed correctly without reading the page back. A one-cycle start pulse carries a buffer choice and a 24-bit page address. The sequencer then sends a compare-page-to-buffer command in a single chip-select window. It releases chip select so the flash begins its internal comparison, and then reads the status register in repeated short transactions. Each poll is one status-read opcode followed by one returned byte. Polling stops once the ready bit of that byte is set. The verdict comes from the compare bit of the same byte.

The SPI clock idles high and is the system clock divided by an even ratio. The device drives MOSI on falling edges, and the sequencer captures MISO on rising edges. Polling is bounded by a cycle counter sized from the clock frequency. The counter covers the worst-case compare time of 400 µs plus a 25% margin. If the flash never reports ready within that bound, the run ends with a timeout verdict. A parameter declares whether the flash has a second page buffer. Asking for a missing buffer is refused at once with an error pulse, and no SPI activity follows.

Top module: `pv_seq`

## Requirements
- R1: The command opcode is 0x60 when buf_sel_i is 0 (first buffer) and 0x61 when buf_sel_i is 1 (second buffer).
- R2: The command transaction is one chip-select-low window of exactly 32 SPI clocks: the opcode, then address bits 23:16, 15:8 and 7:0, each byte sent most-significant bit first.
- R3: Chip select falls only while the SPI clock is high, and MOSI changes only while the SPI clock is low.
- R4: After the command, the sequencer issues status polls as separate chip-select windows of 16 clocks each: the status opcode (default 0xD7) followed by 8 clocks that capture MISO. Within a byte, the SPI clock period is SCK_DIV system clocks.
- R5: Polling repeats while status bit 7 reads 0. On the first poll that returns bit 7 = 1, done_o pulses for one cycle and mismatch_o takes status bit 6 (1 = pages differ).
- R6: mismatch_o and timeout_o hold their values after done_o until the next accepted start.
- R7: When the second buffer is absent (HAS_BUF2 = 0) and buf_sel_i = 1, sel_err_o pulses for one cycle. Chip select stays high, busy_o stays low and done_o does not pulse.
- R8: If the flash does not report ready within TMO_CYC system cycles of the command (TMO_CYC = 1.25 × CLK_HZ × 400 µs), the run ends after the current poll with timeout_o = 1, mismatch_o = 0, a done_o pulse and chip select high.
- R9: busy_o is high from the cycle after an accepted start until done_o. Start pulses while busy_o is high are ignored.
- R10: After reset: spi_cs_n_o = 1, spi_sck_o = 1, and busy_o, done_o, mismatch_o, timeout_o and sel_err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to verify a page |
| buf_sel_i | input | 1 | Buffer choice: 0 first, 1 second |
| addr_i | input | 24 | Page address sent with the command |
| busy_o | output | 1 | Verify run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| mismatch_o | output | 1 | Page differs from buffer (held) |
| timeout_o | output | 1 | Flash never reported ready (held) |
| sel_err_o | output | 1 | One-cycle pulse: selected buffer is absent |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| spi_sck_o | output | 1 | SPI clock, idles high |
| spi_mosi_o | output | 1 | SPI data to flash |
| spi_miso_i | input | 1 | SPI data from flash |

## Verification
Suppose the byte shifter or byte counter slipped. The flash model would then capture a wrong opcode, a wrong address or a clock count other than 32 when the command window closes. The scoreboard reports this at the done pulse of that same run. A sequencer that misread the status byte would stop polling one poll early or late, or return the wrong verdict. This shows as a wrong poll count or a wrong mismatch value at done, within one poll period of the fault. A broken timeout counter either ends a healthy run early with timeout set, or lets a silent flash run past the bound. A broken buffer check starts a chip-select window when it should not. Both of these show within a few cycles of the start pulse, or at the bound.

// File: rtl/pv_pkg.sv
package pv_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CMD,
      S_GAP,
      S_POLL_OP,
      S_POLL_RD,
      S_DECIDE
   } pv_state_e;

   localparam logic [7:0] OPC_CMP_BUF1 = 8'h60;
   localparam logic [7:0] OPC_CMP_BUF2 = 8'h61;

   localparam int STAT_READY_BIT = 7;
   localparam int STAT_DIFF_BIT  = 6;

endpackage

// File: rtl/pv_spi_byte.sv
module pv_spi_byte #(
   parameter int HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_i,
   input  logic [7:0] tx_i,
   input  logic       miso_i,
   output logic       sck_o,
   output logic       mosi_o,
   output logic [7:0] rx_o,
   output logic       done_o
);

   localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [HW-1:0] HLAST = HW'(HALF - 1);

   logic          act_q;
   logic          hi_q;
   logic [HW-1:0] hcnt_q;
   logic [2:0]    bitn_q;
   logic [7:0]    sh_q;

   initial begin
      assert (HALF >= 1) else $error("pv_spi_byte: HALF must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         hi_q   <= 1'b0;
         hcnt_q <= '0;
         bitn_q <= '0;
         sh_q   <= '0;
         sck_o  <= 1'b1;
         mosi_o <= 1'b0;
         rx_o   <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (go_i) begin
            act_q  <= 1'b1;
            hi_q   <= 1'b0;
            hcnt_q <= '0;
            bitn_q <= '0;
            sh_q   <= tx_i;
            sck_o  <= 1'b0;
            mosi_o <= tx_i[7];
         end else if (act_q) begin
            if (hcnt_q == HLAST) begin
               hcnt_q <= '0;
               if (!hi_q) begin
                  sck_o <= 1'b1;
                  rx_o  <= {rx_o[6:0], miso_i};
                  hi_q  <= 1'b1;
               end else if (bitn_q == 3'd7) begin
                  act_q  <= 1'b0;
                  done_o <= 1'b1;
               end else begin
                  bitn_q <= bitn_q + 3'd1;
                  sh_q   <= {sh_q[6:0], 1'b0};
                  sck_o  <= 1'b0;
                  mosi_o <= sh_q[6];
                  hi_q   <= 1'b0;
               end
            end else begin
               hcnt_q <= hcnt_q + HW'(1);
            end
         end
      end
   end

   // R3: data only moves in the low half of the SPI clock
   a_r3_mosi_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mosi_o) |-> !sck_o);

   // R4: a byte completes with the clock parked high
   a_r4_done_parks_high: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> sck_o);

endmodule

// File: rtl/pv_tmo_timer.sv
module pv_tmo_timer #(
   parameter int LIMIT = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic exp_o
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] CLIM = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (LIMIT >= 1) else $error("pv_tmo_timer: LIMIT must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (run_i && cnt_q != CLIM) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign exp_o = (cnt_q == CLIM);

   // R8: expiry is sticky until the next run clears it
   a_r8_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_o && !clr_i) |=> exp_o);

endmodule

// File: rtl/pv_seq.sv
module pv_seq
   import pv_pkg::*;
#(
   parameter int          CLK_HZ   = 200_000_000,
   parameter int          SCK_DIV  = 4,
   parameter int          COMP_US  = 400,
   parameter bit          HAS_BUF2 = 1'b1,
   parameter logic [7:0]  STAT_OP  = 8'hD7,
   parameter int          GAP_CYC  = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        buf_sel_i,
   input  logic [23:0] addr_i,
   output logic        busy_o,
   output logic        done_o,
   output logic        mismatch_o,
   output logic        timeout_o,
   output logic        sel_err_o,
   output logic        spi_cs_n_o,
   output logic        spi_sck_o,
   output logic        spi_mosi_o,
   input  logic        spi_miso_i
);

   localparam int CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int TMO_CYC    = CYC_PER_US * COMP_US + (CYC_PER_US * COMP_US) / 4;
   localparam int HALF       = SCK_DIV / 2;
   localparam int GW         = $clog2(GAP_CYC + 1);
   localparam logic [GW-1:0] GLAST = GW'(GAP_CYC - 1);

   initial begin
      assert (SCK_DIV >= 2 && SCK_DIV % 2 == 0)
         else $error("pv_seq: SCK_DIV must be even and at least 2");
      assert (CYC_PER_US >= 1)
         else $error("pv_seq: CLK_HZ must be at least 1 MHz");
      assert (GAP_CYC >= 1)
         else $error("pv_seq: GAP_CYC must be at least 1");
   end

   pv_state_e   state_q;
   logic [1:0]  byte_idx_q;
   logic [31:0] frame_q;
   logic [7:0]  tx_q;
   logic        go_q;
   logic [GW-1:0] gap_q;
   logic        byte_done;
   logic [7:0]  rx_byte;
   logic        tmr_exp;
   logic        tmr_run;
   logic        accept;
   logic [7:0]  opc_w;
   logic        sel_bad;

   // buffer choice: variant picked by whether a second buffer exists
   generate
      if (HAS_BUF2) begin : g_two_buf
         assign opc_w   = buf_sel_i ? OPC_CMP_BUF2 : OPC_CMP_BUF1;
         assign sel_bad = 1'b0;
      end else begin : g_one_buf
         assign opc_w   = OPC_CMP_BUF1;
         assign sel_bad = buf_sel_i;
      end
   endgenerate

   assign accept  = (state_q == S_IDLE) && start_i && !sel_bad;
   assign tmr_run = (state_q == S_GAP) || (state_q == S_POLL_OP) ||
                    (state_q == S_POLL_RD) || (state_q == S_DECIDE);

   pv_spi_byte #(.HALF(HALF)) u_byte (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (go_q),
      .tx_i   (tx_q),
      .miso_i (spi_miso_i),
      .sck_o  (spi_sck_o),
      .mosi_o (spi_mosi_o),
      .rx_o   (rx_byte),
      .done_o (byte_done)
   );

   pv_tmo_timer #(.LIMIT(TMO_CYC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (accept),
      .run_i (tmr_run),
      .exp_o (tmr_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         byte_idx_q <= '0;
         frame_q    <= '0;
         tx_q       <= '0;
         go_q       <= 1'b0;
         gap_q      <= '0;
         busy_o     <= 1'b0;
         done_o     <= 1'b0;
         mismatch_o <= 1'b0;
         timeout_o  <= 1'b0;
         sel_err_o  <= 1'b0;
         spi_cs_n_o <= 1'b1;
      end else begin
         go_q      <= 1'b0;
         done_o    <= 1'b0;
         sel_err_o <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start_i && sel_bad) begin
                  sel_err_o <= 1'b1;
               end else if (accept) begin
                  frame_q    <= {opc_w, addr_i} << 8;
                  tx_q       <= opc_w;
                  go_q       <= 1'b1;
                  byte_idx_q <= '0;
                  spi_cs_n_o <= 1'b0;
                  busy_o     <= 1'b1;
                  mismatch_o <= 1'b0;
                  timeout_o  <= 1'b0;
                  state_q    <= S_CMD;
               end
            end
            S_CMD: begin
               if (byte_done) begin
                  if (byte_idx_q == 2'd3) begin
                     spi_cs_n_o <= 1'b1;
                     gap_q      <= '0;
                     state_q    <= S_GAP;
                  end else begin
                     byte_idx_q <= byte_idx_q + 2'd1;
                     tx_q       <= frame_q[31:24];
                     frame_q    <= frame_q << 8;
                     go_q       <= 1'b1;
                  end
               end
            end
            S_GAP: begin
               if (gap_q == GLAST) begin
                  spi_cs_n_o <= 1'b0;
                  tx_q       <= STAT_OP;
                  go_q       <= 1'b1;
                  state_q    <= S_POLL_OP;
               end else begin
                  gap_q <= gap_q + GW'(1);
               end
            end
            S_POLL_OP: begin
               if (byte_done) begin
                  tx_q    <= 8'h00;
                  go_q    <= 1'b1;
                  state_q <= S_POLL_RD;
               end
            end
            S_POLL_RD: begin
               if (byte_done) begin
                  spi_cs_n_o <= 1'b1;
                  state_q    <= S_DECIDE;
               end
            end
            S_DECIDE: begin
               if (rx_byte[STAT_READY_BIT]) begin
                  mismatch_o <= rx_byte[STAT_DIFF_BIT];
                  done_o     <= 1'b1;
                  busy_o     <= 1'b0;
                  state_q    <= S_IDLE;
               end else if (tmr_exp) begin
                  timeout_o  <= 1'b1;
                  done_o     <= 1'b1;
                  busy_o     <= 1'b0;
                  state_q    <= S_IDLE;
               end else begin
                  gap_q   <= '0;
                  state_q <= S_GAP;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   // R3: select is taken only while the clock sits high
   a_r3_cs_falls_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n_o) |-> spi_sck_o);

   // R4: no clock activity outside a select window
   a_r4_sck_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n_o |-> spi_sck_o);

   // R9: completion closes a busy run
   a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R7: a refused request leaves the bus quiet
   a_r7_err_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err_o |-> (spi_cs_n_o && !busy_o));

   // R5: completion and refusal never coincide
   a_r5_end_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, sel_err_o}));

   // R8: a timeout verdict needs an expired poll window
   a_r8_timeout_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_o) |-> $past(tmr_exp));

   // R6: verdict flags change only at a start or at completion
   a_r6_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_o && !busy_o) |-> ($stable(mismatch_o) && $stable(timeout_o)));

endmodule

// File: tb/tb_pv_seq.sv
`timescale 1ns/1ps
module tb_pv_seq;

   localparam int DIV = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // main instance: two buffers, real clock rate
   logic        start = 1'b0, bsel = 1'b0;
   logic [23:0] addr = '0;
   logic busy, done, mis, tmo, serr, cs_n, sck, mosi;
   logic miso = 1'b0;

   pv_seq #(.SCK_DIV(DIV), .HAS_BUF2(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .buf_sel_i(bsel), .addr_i(addr),
      .busy_o(busy), .done_o(done), .mismatch_o(mis), .timeout_o(tmo),
      .sel_err_o(serr), .spi_cs_n_o(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi),
      .spi_miso_i(miso));

   // second instance: one buffer, bound scaled to 5000 cycles, flash never ready
   logic        start1 = 1'b0, bsel1 = 1'b0;
   logic busy1, done1, mis1, tmo1, serr1, cs1, sck1, mosi1;

   pv_seq #(.CLK_HZ(10_000_000), .SCK_DIV(DIV), .HAS_BUF2(1'b0)) dut1 (
      .clk(clk), .rst_n(rst_n), .start_i(start1), .buf_sel_i(bsel1), .addr_i(24'h00ABCD),
      .busy_o(busy1), .done_o(done1), .mismatch_o(mis1), .timeout_o(tmo1),
      .sel_err_o(serr1), .spi_cs_n_o(cs1), .spi_sck_o(sck1), .spi_mosi_o(mosi1),
      .spi_miso_i(1'b0));

   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- flash model ----------------
   int          ready_after = 0;
   bit          cmp_bit = 0;
   int          tcount = 0, npolls = 0, bitcnt = 0;
   bit          poll_ok = 1, per_ok = 1;
   logic [31:0] rxsh = '0, frame_cap = '0;
   int          frame_bits = 0;
   logic [7:0]  stat = '0;
   realtime     last_rise = 0;

   always @(negedge cs_n) begin
      bitcnt = 0;
      rxsh   = '0;
      if (tcount > 0)
         stat = (npolls >= ready_after) ? {1'b1, cmp_bit, 6'b0} : 8'h3F;
   end

   always @(posedge sck) if (!cs_n) begin
      if (bitcnt % 8 != 0 && ($realtime - last_rise) != DIV * 5.0) per_ok = 0;
      last_rise = $realtime;
      rxsh   = {rxsh[30:0], mosi};
      bitcnt = bitcnt + 1;
   end

   always @(negedge sck) if (!cs_n) begin
      if (bitcnt >= 8 && bitcnt < 16) miso <= stat[7 - (bitcnt - 8)];
      else miso <= 1'b0;
   end

   always @(posedge cs_n) if (rst_n) begin
      if (tcount == 0) begin
         frame_cap  = rxsh;
         frame_bits = bitcnt;
      end else begin
         if (bitcnt != 16 || rxsh[15:8] != 8'hD7) poll_ok = 0;
         npolls = npolls + 1;
      end
      tcount = tcount + 1;
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [31:0] frame;
      logic        mis;
      int          polls;
   } exp_t;
   exp_t q[$];
   int ops_seen = 0;

   always @(negedge clk) if (rst_n && done) begin
      exp_t e;
      if (q.size() == 0) begin
         chk(0, "R5 unexpected done", 1, 0);
      end else begin
         e = q.pop_front();
         chk(frame_cap[31:24] == e.frame[31:24], "R1 opcode", frame_cap[31:24], e.frame[31:24]);
         chk(frame_cap == e.frame && frame_bits == 32, "R2 frame", frame_cap, e.frame);
         chk(npolls == e.polls && poll_ok, "R4 poll count/opcode", npolls, e.polls);
         chk(per_ok, "R4 sck period", per_ok, 1);
         chk(mis == e.mis && !tmo, "R5 verdict", {tmo, mis}, {1'b0, e.mis});
      end
      ops_seen++;
   end

   task automatic run_op(input bit sel, input logic [23:0] a, input int nbusy, input bit cmp);
      exp_t e;
      int target;
      ready_after = nbusy; cmp_bit = cmp;
      tcount = 0; npolls = 0; poll_ok = 1; per_ok = 1;
      e.frame = {(sel ? 8'h61 : 8'h60), a};
      e.mis   = cmp;
      e.polls = nbusy + 1;
      q.push_back(e);
      target = ops_seen + 1;
      @(negedge clk); start = 1; bsel = sel; addr = a;
      @(negedge clk); start = 0;
      chk(busy && !cs_n, "R9 busy after start", {busy, cs_n}, 2'b10);
      repeat (3) @(negedge clk);
      start = 1; addr = ~a; bsel = ~sel;   // ignored: block is busy
      @(negedge clk); start = 0;
      while (ops_seen < target) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(mis == cmp && !busy && cs_n, "R6 verdict held", {busy, mis}, {1'b0, cmp});
   endtask

   initial begin
      #(5.0 * 150000);
      chk(0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int t0;
      int err_seen;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk({cs_n, sck, busy, done, mis, tmo, serr} == 7'b1100000, "R10 reset outputs",
          {cs_n, sck, busy, done, mis, tmo, serr}, 7'b1100000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_op(1'b0, 24'hA5C30F, 0, 1'b0);
      run_op(1'b1, 24'h000001, 2, 1'b1);
      run_op(1'b0, 24'hFFFFFE, 1, 1'b1);
      run_op(1'b1, 24'h123456, 3, 1'b0);

      // R7: second buffer absent
      @(negedge clk); start1 = 1; bsel1 = 1;
      @(negedge clk); start1 = 0; bsel1 = 0;
      chk(serr1 && !busy1 && cs1, "R7 sel error pulse", {serr1, busy1, cs1}, 3'b101);
      err_seen = 0;
      repeat (20) begin
         @(negedge clk);
         if (!cs1 || done1 || busy1 || serr1) err_seen++;
      end
      chk(err_seen == 0, "R7 bus stays quiet", err_seen, 0);

      // R8: flash never ready, bound 5000 cycles
      @(negedge clk); start1 = 1;
      @(negedge clk); start1 = 0;
      t0 = 1;
      while (!done1 && t0 < 8000) begin @(negedge clk); t0++; end
      chk(done1 && tmo1 && !mis1 && cs1, "R8 timeout verdict",
          {done1, tmo1, mis1, cs1}, 4'b1101);
      chk(t0 >= 5000 && t0 < 5300, "R8 timeout latency", t0, 5000);
      repeat (5) @(negedge clk);
      chk(tmo1 && !busy1, "R6 timeout held", {tmo1, busy1}, 2'b10);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule